// File: doc/BRIEF.md
# Fast A20 Gate Decoder

This block sits beside a keyboard-controller style host port and takes the A20 gate command sequence away from the local processor. Each 8-bit host write goes either to the command port or to the data port, selected by a host address bit. When the host sends the gate-arming command and then a data byte, the block sets the gate output straight from one bit of that byte. The processor is never interrupted for these writes. Any write the block does not consume sets a sticky flag for the processor, which clears it with a one-cycle pulse.

The host write strobe and the shutdown input are asynchronous. Each passes through a synchroniser, and the strobe is edge-detected, so every write is decoded exactly once. A shutdown input, enabled by two control bits, releases the gate output enable and masks the host strobe internally. Normal operation returns when the shutdown input goes high again.

Top module: `a20_gate_decoder`

## Requirements
- R1: After synchronous reset, gate_out is 1, gate_oe is 1 and cpu_flag is 0.
- R2: A write with host_cmd=1 is a command and a write with host_cmd=0 is data. The command 0xD1 arms the sequencer, leaves gate_out unchanged and does not set cpu_flag.
- R3: A data write while armed copies bit 1 of the data byte to gate_out (1 = on, 0 = off) and does not set cpu_flag.
- R4: The command 0xFF right after a gate-loading data write closes the sequence. It does not set cpu_flag and does not change gate_out.
- R5: If any command other than 0xFF or 0xD1 follows a gate-loading data write, gate_out keeps its new value and cpu_flag is set.
- R6: A command other than 0xD1 while armed cancels the sequence. cpu_flag is set, gate_out is unchanged, and a following data write no longer changes the gate.
- R7: A repeated 0xD1 while armed sets no flag and keeps the sequencer armed, so the next data write still loads the gate.
- R8: A 0xD1 right after a gate-loading data write starts a new sequence with no flag, so sequences can run back to back.
- R9: A data write with no armed 0xD1 before it sets cpu_flag and leaves gate_out unchanged. This includes a second data write after a load. A 0xFF command outside a sequence also sets cpu_flag.
- R10: cpu_flag stays set until a one-cycle cpu_flag_clr pulse clears it. If a flagged write and a clear land in the same cycle, the flag stays set.
- R11: When sd_en_a and sd_en_b are both 1 and host_sd_n is low, gate_oe goes to 0 and host writes are ignored. gate_oe returns to 1 once host_sd_n is high. If either enable bit is 0, host_sd_n has no effect.
- R12: Each rising edge of host_wr is decoded exactly once. Its effect appears at the third rising clock edge after the strobe rises (SYNC_STAGES+1 with the default SYNC_STAGES=2). Holding the strobe high does not repeat the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Asynchronous host write strobe, active high |
| host_cmd | input | 1 | Port select: 1 = command, 0 = data |
| host_byte | input | DATA_W | Host write data, held stable while host_wr is high |
| sd_en_a | input | 1 | First shutdown enable bit |
| sd_en_b | input | 1 | Second shutdown enable bit |
| host_sd_n | input | 1 | Asynchronous shutdown request, active low |
| cpu_flag_clr | input | 1 | One-cycle clear pulse for cpu_flag |
| cpu_flag | output | 1 | Sticky flag: a write was left for the processor |
| gate_out | output | 1 | Registered A20 gate value |
| gate_oe | output | 1 | Output enable for gate_out, 0 during shutdown |

## Verification
Both host_wr and host_sd_n take effect at the third rising clock edge after they change, because of two synchroniser stages and one decode register. The bench therefore drives every input on a falling edge and samples outputs only on falling edges. It holds each strobe for four falling edges before reading gate_out and cpu_flag. To check the timing itself, the bench reads cpu_flag after exactly two rising edges, where it must still be clear, and again after the third, where it must be set. It also places a clear pulse on the very cycle a flagged write is decoded, to check that the set wins.

// File: rtl/a20_pkg.sv
package a20_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_LOADED = 2'd2
  } seq_t;
endpackage

// File: rtl/a20_sync.sv
module a20_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/a20_seq.sv
module a20_seq
  import a20_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              GATE_BIT = 1,
  parameter logic [DATA_W-1:0] ARM_CODE = 8'hD1,
  parameter logic [DATA_W-1:0] END_CODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_v,
  input  logic              is_cmd,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              flag_clr,
  output logic              gate_q,
  output logic              flag_q
);
  seq_t state, nxt_state;
  logic load, raise;

  always_comb begin
    nxt_state = state;
    load      = 1'b0;
    raise     = 1'b0;
    if (wr_v) begin
      if (is_cmd) begin
        if (wr_byte == ARM_CODE) begin
          nxt_state = SEQ_ARMED;
        end else begin
          nxt_state = SEQ_IDLE;
          raise     = !(state == SEQ_LOADED && wr_byte == END_CODE);
        end
      end else if (state == SEQ_ARMED) begin
        load      = 1'b1;
        nxt_state = SEQ_LOADED;
      end else begin
        raise     = 1'b1;
        nxt_state = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_IDLE;
      gate_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      state <= nxt_state;
      if (load) gate_q <= wr_byte[GATE_BIT];
      if (raise) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  AST_ARM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (wr_v && is_cmd && wr_byte == ARM_CODE && !flag_q && !flag_clr) |=> (!flag_q && state == SEQ_ARMED)); // R2
  AST_GATE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_v && !is_cmd && state == SEQ_ARMED) |=> (gate_q == $past(wr_byte[GATE_BIT]))); // R3
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_v && !is_cmd && state == SEQ_ARMED) |=> $stable(gate_q)); // R6
  AST_FOREIGN_CMD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wr_v && is_cmd && wr_byte != ARM_CODE && !(state == SEQ_LOADED && wr_byte == END_CODE)) |=> flag_q); // R5
  AST_STRAY_DATA_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wr_v && !is_cmd && state != SEQ_ARMED) |=> flag_q); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q); // R10
endmodule

// File: rtl/a20_gate_decoder.sv
module a20_gate_decoder #(
  parameter int              DATA_W      = 8,
  parameter int              GATE_BIT    = 1,
  parameter int              SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ARM_CODE  = 8'hD1,
  parameter logic [DATA_W-1:0] END_CODE  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_cmd,
  input  logic [DATA_W-1:0] host_byte,
  input  logic              sd_en_a,
  input  logic              sd_en_b,
  input  logic              host_sd_n,
  input  logic              cpu_flag_clr,
  output logic              cpu_flag,
  output logic              gate_out,
  output logic              gate_oe
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] raw_in, synced;
  logic wr_s, sd_n_s, sd_active;
  logic wr_int, wr_prev, wr_fire, cmd_int;
  logic oe_q;

  assign raw_in = {host_sd_n, host_wr};

  a20_sync #(
    .W       (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .q_sync  (synced)
  );

  assign wr_s      = synced[0];
  assign sd_n_s    = synced[1];
  assign sd_active = sd_en_a & sd_en_b & ~sd_n_s;
  assign wr_int    = wr_s & ~sd_active;
  assign cmd_int   = host_cmd & ~sd_active;
  assign wr_fire   = wr_int & ~wr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      oe_q    <= 1'b1;
    end else begin
      wr_prev <= wr_int;
      oe_q    <= ~sd_active;
    end
  end

  a20_seq #(
    .DATA_W   (DATA_W),
    .GATE_BIT (GATE_BIT),
    .ARM_CODE (ARM_CODE),
    .END_CODE (END_CODE)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr_v     (wr_fire),
    .is_cmd   (cmd_int),
    .wr_byte  (host_byte),
    .flag_clr (cpu_flag_clr),
    .gate_q   (gate_out),
    .flag_q   (cpu_flag)
  );

  assign gate_oe = oe_q;

  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !wr_fire); // R12
  AST_SD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    sd_active |=> !gate_oe); // R11
  AST_SD_RESTORE: assert property (@(posedge clk) disable iff (rst)
    !sd_active |=> gate_oe); // R11
endmodule

// File: tb/a20_gate_decoder_bench.sv
`timescale 1ns/1ps
module a20_gate_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_cmd = 1'b0;
  logic [7:0] host_byte = 8'h00;
  logic sd_en_a = 1'b0, sd_en_b = 1'b0, host_sd_n = 1'b1, cpu_flag_clr = 1'b0;
  logic cpu_flag, gate_out, gate_oe;

  int checks = 0, errors = 0;
  int m_st = 0;           // 0 idle, 1 armed, 2 loaded
  logic m_gate = 1'b1, m_flag = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  a20_gate_decoder u_a20_gate_decoder (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_cmd(host_cmd), .host_byte(host_byte),
    .sd_en_a(sd_en_a), .sd_en_b(sd_en_b), .host_sd_n(host_sd_n), .cpu_flag_clr(cpu_flag_clr),
    .cpu_flag(cpu_flag), .gate_out(gate_out), .gate_oe(gate_oe)
  );

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic model(input bit cmd, input logic [7:0] b);
    if (cmd) begin
      if (b == 8'hD1) m_st = 1;
      else begin
        if (!(m_st == 2 && b == 8'hFF)) m_flag = 1'b1;
        m_st = 0;
      end
    end else if (m_st == 1) begin
      m_gate = b[1]; m_st = 2;
    end else begin
      m_flag = 1'b1; m_st = 0;
    end
  endtask

  task automatic host_write(input bit cmd, input logic [7:0] b, input string tag, input int hold = 4);
    @(negedge clk);
    host_cmd = cmd; host_byte = b; host_wr = 1'b1;
    repeat (hold) @(negedge clk);
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
    model(cmd, b);
    check(tag, "gate_out", gate_out, m_gate);
    check(tag, "cpu_flag", cpu_flag, m_flag);
  endtask

  task automatic clear_flag();
    @(negedge clk); cpu_flag_clr = 1'b1;
    @(negedge clk); cpu_flag_clr = 1'b0;
    m_flag = 1'b0;
    check("R10", "cpu_flag after clear", cpu_flag, 1'b0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "gate_out", gate_out, 1'b1);
    check("R1", "gate_oe", gate_oe, 1'b1);
    check("R1", "cpu_flag", cpu_flag, 1'b0);

    // R2 R3 R4: full sequences over every data byte
    for (int b = 0; b < 256; b++) begin
      host_write(1'b1, 8'hD1, "R2");
      host_write(1'b0, 8'(b), "R3");
      host_write(1'b1, 8'hFF, "R4");
    end

    // R6 R7 R5: every command while armed, then a probing data write
    for (int c = 0; c < 256; c++) begin
      host_write(1'b1, 8'hD1, "R2");
      host_write(1'b1, 8'(c), (c == 8'hD1) ? "R7" : "R6");
      host_write(1'b0, {6'd0, ~m_gate, 1'b0}, (c == 8'hD1) ? "R7" : "R6");
      host_write(1'b1, 8'(c ^ 8'h5A), "R5");
      if (m_flag) clear_flag();
    end

    // R8: back-to-back sequences
    host_write(1'b1, 8'hD1, "R8");
    host_write(1'b0, 8'h02, "R8");
    host_write(1'b1, 8'hD1, "R8");
    host_write(1'b0, 8'hFD, "R8");
    host_write(1'b1, 8'hD1, "R8");
    host_write(1'b0, 8'hFF, "R8");

    // R9: stray data, second data after load, 0xFF outside a sequence
    host_write(1'b0, 8'h00, "R9");
    clear_flag();
    host_write(1'b1, 8'hD1, "R9");
    host_write(1'b0, 8'h00, "R9");
    host_write(1'b0, 8'h02, "R9");
    clear_flag();
    host_write(1'b1, 8'hFF, "R9");
    clear_flag();

    // R12: held strobe on a loading data write must not act twice
    host_write(1'b1, 8'hD1, "R12");
    host_write(1'b0, 8'h02, "R12", 20);

    // R12: latency of exactly three rising edges
    @(negedge clk);
    host_cmd = 1'b1; host_byte = 8'h33; host_wr = 1'b1;
    repeat (2) @(negedge clk);
    check("R12", "cpu_flag before third edge", cpu_flag, 1'b0);
    @(negedge clk);
    check("R12", "cpu_flag at third edge", cpu_flag, 1'b1);
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
    m_flag = 1'b1; m_st = 0;
    clear_flag();

    // R10: set wins over a simultaneous clear
    @(negedge clk);
    host_cmd = 1'b0; host_byte = 8'h00; host_wr = 1'b1;
    repeat (2) @(negedge clk);
    cpu_flag_clr = 1'b1;
    @(negedge clk);
    cpu_flag_clr = 1'b0;
    check("R10", "cpu_flag set beats clear", cpu_flag, 1'b1);
    repeat (3) @(negedge clk);
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "cpu_flag still set", cpu_flag, 1'b1);
    m_flag = 1'b1; m_st = 0;
    clear_flag();

    // R11: one enable only, shutdown has no effect
    sd_en_a = 1'b1; sd_en_b = 1'b0; host_sd_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R11", "gate_oe with one enable", gate_oe, 1'b1);
    host_write(1'b1, 8'hD1, "R11");
    host_write(1'b0, 8'h00, "R11");
    host_sd_n = 1'b1;

    // R11: full shutdown ignores writes and releases the enable
    host_write(1'b1, 8'hD1, "R11");
    sd_en_b = 1'b1; host_sd_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R11", "gate_oe in shutdown", gate_oe, 1'b0);
    @(negedge clk); host_cmd = 1'b0; host_byte = 8'h02; host_wr = 1'b1;
    repeat (4) @(negedge clk); host_wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "gate_out during shutdown", gate_out, m_gate);
    check("R11", "cpu_flag during shutdown", cpu_flag, 1'b0);
    host_sd_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "gate_oe restored", gate_oe, 1'b1);
    host_write(1'b0, 8'h02, "R11");

    done = 1'b1;
    report();
  end
endmodule